// File: doc/BRIEF.md
# Hashed MAC Forwarding Lookup

This block makes the ingress forwarding decision for an Ethernet frame. It receives the first fourteen header bytes of a frame together with the number of the port the frame arrived on. It takes the destination address from the front of the header and folds it into a short hash index. All ways of a set-associative address table are read at that index at the same time. Each stored address is compared with the destination address. The block then returns one of three outcomes:

- forward, with a port mask and a priority queue;
- drop, because the source port is disabled;
- drop, because no way holds the address.

Configuration logic fills the table through a write port that selects a way, an index and a complete entry. A second write port sets one enable bit for each source port. The lookup is a two-stage pipeline and accepts a new header every clock cycle.

Top module: `mac_fwd_lookup`

## Requirements
- R1: A header presented with `hdr_valid` high in cycle c produces exactly one result with `res_valid` high in cycle c+2. Headers may be presented in consecutive cycles, and each one gets its own result in order.
- R2: The header is read as destination (bytes 0 to 5), then source (bytes 6 to 11), then type/length (bytes 12 and 13). Byte 0 sits in `hdr_data[111:104]`, and the destination occupies `hdr_data[111:64]` with bit 47 as its most significant bit. The table index is the XOR of destination bits 47:36, 35:24, 23:12 and 11:0.
- R3: When a valid entry at the hashed index stores an address equal to the destination and the source port is enabled, the result has `res_fwd`=1, `res_drop`=0, and the entry's port mask and queue on `res_mask` and `res_queue`.
- R4: When the source port is enabled and no way hits, the result has `res_drop`=1, `res_drop_id`=1, `res_fwd`=0, and `res_mask` and `res_queue` equal to zero.
- R5: When the source port is disabled, the result has `res_drop`=1 and `res_drop_id`=0, with mask and queue zero, even if the table holds the destination.
- R6: An entry written with `tbl_valid`=0 never produces a hit.
- R7: When several ways hit, the lowest-numbered way supplies the mask and queue.
- R8: A table write in the same cycle as a lookup to that index does not affect that lookup. A lookup presented in a later cycle sees the written entry.
- R9: After reset, `res_valid` is 0, every source port is disabled, and every table entry is invalid.
- R10: The source address and type/length bytes have no effect on the result.
- R11: An enable write in the same cycle as a header from that port does not affect that header. A header presented in a later cycle sees the new enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header strobe, one frame per cycle |
| hdr_src_port | input | PORT_W | Arrival port of the frame |
| hdr_data | input | 112 | First 14 header bytes, byte 0 in the top byte |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_way | input | WAY_W | Way selected for the write |
| tbl_index | input | IDX_W | Index written |
| tbl_valid | input | 1 | Valid bit of the written entry |
| tbl_addr | input | 48 | Address stored in the entry |
| tbl_mask | input | NPORTS | Port mask stored in the entry |
| tbl_queue | input | 3 | Queue stored in the entry |
| en_we | input | 1 | Port enable write strobe |
| en_port | input | PORT_W | Port whose enable is written |
| en_on | input | 1 | New enable value |
| res_valid | output | 1 | Result strobe |
| res_fwd | output | 1 | Frame forwarded |
| res_mask | output | NPORTS | Destination port mask |
| res_queue | output | 3 | Destination queue |
| res_drop | output | 1 | Frame dropped |
| res_drop_id | output | 8 | Drop reason: 0 port disabled, 1 no match |

## Verification
Every internal fault reaches the ports two cycles after the header that exposes it. A corrupted hash index, a stuck valid bit or a wrong compare turns an expected hit into a miss (drop reason 1), or a miss into a forward. A faulty priority pick shows up as the mask and queue of the wrong way when the same address is stored in two ways. A stale or wrongly written enable bit changes the drop reason to 0, or fails to. Timing faults between write ports and in-flight lookups show only in the exact cycle of the collision, so the bench issues the write and the lookup in the same cycle and again one cycle apart.

// File: rtl/mac_fwd_pkg.sv
package mac_fwd_pkg;
    localparam int MAC_W   = 48;
    localparam int HDR_W   = 112;
    localparam int QUEUE_W = 3;
    localparam int DROP_W  = 8;

    localparam logic [DROP_W-1:0] DROP_PORT_OFF = 8'd0;
    localparam logic [DROP_W-1:0] DROP_NO_MATCH = 8'd1;

    typedef enum logic [1:0] {
        KIND_IDLE,
        KIND_FWD,
        KIND_PORT_OFF,
        KIND_MISS
    } res_kind_t;

    typedef struct packed {
        logic [MAC_W-1:0] dest;
        logic [MAC_W-1:0] src;
        logic [15:0]      ethtype;
    } eth_hdr_t;

    typedef struct packed {
        logic             valid;
        logic             port_on;
        logic [MAC_W-1:0] dest;
    } lkup_ctx_t;
endpackage

// File: rtl/mac_fwd_hash.sv
module mac_fwd_hash
    import mac_fwd_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [MAC_W-1:0] dest,
    output logic [IDX_W-1:0] index
);
    localparam int SLICES = (MAC_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = SLICES * IDX_W;

    logic [PAD_W-1:0] padded;
    assign padded = PAD_W'(dest);

    always_comb begin
        index = '0;
        for (int s = 0; s < SLICES; s++) begin
            index = index ^ padded[s*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/mac_fwd_way.sv
module mac_fwd_way
    import mac_fwd_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int NPORTS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [MAC_W-1:0]    wr_addr,
    input  logic [NPORTS-1:0]   wr_mask,
    input  logic [QUEUE_W-1:0]  wr_queue,
    output logic                rd_valid,
    output logic [MAC_W-1:0]    rd_addr,
    output logic [NPORTS-1:0]   rd_mask,
    output logic [QUEUE_W-1:0]  rd_queue
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int ENTRY_W = MAC_W + NPORTS + QUEUE_W;

    logic [ENTRY_W-1:0] store [DEPTH];
    logic [DEPTH-1:0]   live;
    logic [ENTRY_W-1:0] rd_word;

    // Valid bits carry reset; read-before-write keeps in-flight lookups on old data.
    always_ff @(posedge clk) begin
        if (rst) begin
            live     <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= live[rd_idx];
            if (wr_en) live[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        rd_word <= store[rd_idx];
        if (wr_en) store[wr_idx] <= {wr_addr, wr_mask, wr_queue};
    end

    assign {rd_addr, rd_mask, rd_queue} = rd_word;
endmodule

// File: rtl/mac_fwd_select.sv
module mac_fwd_select
    import mac_fwd_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int NPORTS = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ctx_valid,
    input  logic                            ctx_port_on,
    input  logic [WAYS-1:0]                 hit,
    input  logic [WAYS-1:0][NPORTS-1:0]     way_mask,
    input  logic [WAYS-1:0][QUEUE_W-1:0]    way_queue,
    output logic                            res_valid,
    output logic                            res_fwd,
    output logic [NPORTS-1:0]               res_mask,
    output logic [QUEUE_W-1:0]              res_queue,
    output logic                            res_drop,
    output logic [DROP_W-1:0]               res_drop_id
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [WAY_W-1:0] pick;
    res_kind_t        kind;

    always_comb begin
        pick = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit[w]) pick = WAY_W'(w);
        end
        if (!ctx_valid)        kind = KIND_IDLE;
        else if (!ctx_port_on) kind = KIND_PORT_OFF;
        else if (|hit)         kind = KIND_FWD;
        else                   kind = KIND_MISS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_fwd     <= 1'b0;
            res_mask    <= '0;
            res_queue   <= '0;
            res_drop    <= 1'b0;
            res_drop_id <= '0;
        end else begin
            res_valid   <= (kind != KIND_IDLE);
            res_fwd     <= (kind == KIND_FWD);
            res_drop    <= (kind == KIND_PORT_OFF) || (kind == KIND_MISS);
            res_mask    <= (kind == KIND_FWD) ? way_mask[pick]  : '0;
            res_queue   <= (kind == KIND_FWD) ? way_queue[pick] : '0;
            res_drop_id <= (kind == KIND_MISS) ? DROP_NO_MATCH : DROP_PORT_OFF;
        end
    end

    a_r5_port_off_drop: assert property (@(posedge clk) disable iff (rst)
        ctx_valid && !ctx_port_on |=> res_drop && !res_fwd && res_drop_id == DROP_PORT_OFF);

    a_r4_miss_drop: assert property (@(posedge clk) disable iff (rst)
        ctx_valid && ctx_port_on && hit == '0 |=>
        res_drop && res_drop_id == DROP_NO_MATCH && res_mask == '0 && res_queue == '0);

    a_r3_hit_fwd: assert property (@(posedge clk) disable iff (rst)
        ctx_valid && ctx_port_on && hit != '0 |=> res_fwd && !res_drop);
endmodule

// File: rtl/mac_fwd_lookup.sv
module mac_fwd_lookup
    import mac_fwd_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int WAYS   = 4,
    parameter int IDX_W  = 12,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hdr_valid,
    input  logic [PORT_W-1:0]    hdr_src_port,
    input  logic [HDR_W-1:0]     hdr_data,
    input  logic                 tbl_we,
    input  logic [WAY_W-1:0]     tbl_way,
    input  logic [IDX_W-1:0]     tbl_index,
    input  logic                 tbl_valid,
    input  logic [MAC_W-1:0]     tbl_addr,
    input  logic [NPORTS-1:0]    tbl_mask,
    input  logic [QUEUE_W-1:0]   tbl_queue,
    input  logic                 en_we,
    input  logic [PORT_W-1:0]    en_port,
    input  logic                 en_on,
    output logic                 res_valid,
    output logic                 res_fwd,
    output logic [NPORTS-1:0]    res_mask,
    output logic [QUEUE_W-1:0]   res_queue,
    output logic                 res_drop,
    output logic [DROP_W-1:0]    res_drop_id
);
    eth_hdr_t                      hdr;
    logic [IDX_W-1:0]              hash_idx;
    logic [NPORTS-1:0]             port_en;
    lkup_ctx_t                     ctx;
    logic [WAYS-1:0]               hit;
    logic [WAYS-1:0]               rd_valid;
    logic [WAYS-1:0][MAC_W-1:0]    rd_addr;
    logic [WAYS-1:0][NPORTS-1:0]   rd_mask;
    logic [WAYS-1:0][QUEUE_W-1:0]  rd_queue;
    logic                          unused_hdr_bits;

    assign hdr             = eth_hdr_t'(hdr_data);
    assign unused_hdr_bits = ^{hdr.src, hdr.ethtype};

    mac_fwd_hash #(.IDX_W(IDX_W)) u_hash (
        .dest  (hdr.dest),
        .index (hash_idx)
    );

    // Port enable bits; read at header time, so a same-cycle write is not seen.
    always_ff @(posedge clk) begin
        if (rst) begin
            port_en <= '0;
            ctx     <= '0;
        end else begin
            if (en_we && int'(en_port) < NPORTS) port_en[en_port] <= en_on;
            ctx.valid   <= hdr_valid;
            ctx.port_on <= (int'(hdr_src_port) < NPORTS) && port_en[hdr_src_port];
            ctx.dest    <= hdr.dest;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        mac_fwd_way #(.IDX_W(IDX_W), .NPORTS(NPORTS)) u_way (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (hash_idx),
            .wr_en    (tbl_we && int'(tbl_way) == w),
            .wr_idx   (tbl_index),
            .wr_valid (tbl_valid),
            .wr_addr  (tbl_addr),
            .wr_mask  (tbl_mask),
            .wr_queue (tbl_queue),
            .rd_valid (rd_valid[w]),
            .rd_addr  (rd_addr[w]),
            .rd_mask  (rd_mask[w]),
            .rd_queue (rd_queue[w])
        );
        assign hit[w] = rd_valid[w] && (rd_addr[w] == ctx.dest);
    end

    mac_fwd_select #(.WAYS(WAYS), .NPORTS(NPORTS)) u_select (
        .clk         (clk),
        .rst         (rst),
        .ctx_valid   (ctx.valid),
        .ctx_port_on (ctx.port_on),
        .hit         (hit),
        .way_mask    (rd_mask),
        .way_queue   (rd_queue),
        .res_valid   (res_valid),
        .res_fwd     (res_fwd),
        .res_mask    (res_mask),
        .res_queue   (res_queue),
        .res_drop    (res_drop),
        .res_drop_id (res_drop_id)
    );

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        age == 2'd2 |-> res_valid == $past(hdr_valid, 2));

    a_r9_reset_idle: assert property (@(posedge clk) rst |=> !res_valid);

    a_r3_fwd_xor_drop: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_fwd != res_drop));
endmodule

// File: tb/mac_fwd_lookup_bench.sv
module mac_fwd_lookup_bench;
    localparam int NPORTS = 8;
    localparam int NV     = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         hdr_valid = 1'b0;
    logic [2:0]   hdr_src_port = '0;
    logic [111:0] hdr_data = '0;
    logic         tbl_we = 1'b0;
    logic [1:0]   tbl_way = '0;
    logic [11:0]  tbl_index = '0;
    logic         tbl_valid = 1'b0;
    logic [47:0]  tbl_addr = '0;
    logic [7:0]   tbl_mask = '0;
    logic [2:0]   tbl_queue = '0;
    logic         en_we = 1'b0;
    logic [2:0]   en_port = '0;
    logic         en_on = 1'b0;
    logic         res_valid, res_fwd, res_drop;
    logic [7:0]   res_mask, res_drop_id;
    logic [2:0]   res_queue;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    mac_fwd_lookup u_mac_fwd_lookup (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_src_port(hdr_src_port),
        .hdr_data(hdr_data), .tbl_we(tbl_we), .tbl_way(tbl_way), .tbl_index(tbl_index),
        .tbl_valid(tbl_valid), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask),
        .tbl_queue(tbl_queue), .en_we(en_we), .en_port(en_port), .en_on(en_on),
        .res_valid(res_valid), .res_fwd(res_fwd), .res_mask(res_mask),
        .res_queue(res_queue), .res_drop(res_drop), .res_drop_id(res_drop_id)
    );

    localparam logic [47:0] A_DA = 48'h0000_0000_0001;
    localparam logic [47:0] B_DA = 48'h0010_0000_0000;
    localparam logic [47:0] C_DA = 48'hABCD_EF12_3456;
    localparam logic [47:0] D_DA = 48'h0000_0000_0002;
    localparam logic [47:0] E_DA = 48'h1111_1111_1111;
    localparam logic [47:0] F_DA = 48'h0000_0000_0003;
    localparam logic [47:0] G_DA = 48'h0000_0000_0005;

    // Expected kind: 0 forward, 1 miss, 2 port disabled
    localparam logic [47:0] V_DA   [NV] = '{A_DA, B_DA, C_DA, D_DA, E_DA, F_DA, A_DA, D_DA};
    localparam logic [2:0]  V_SRC  [NV] = '{3'd1, 3'd2, 3'd0, 3'd3, 3'd4, 3'd5, 3'd7, 3'd7};
    localparam int          V_KIND [NV] = '{0, 0, 0, 1, 0, 1, 2, 2};
    localparam logic [7:0]  V_MASK [NV] = '{8'h03, 8'h80, 8'h10, 8'h00, 8'h04, 8'h00, 8'h00, 8'h00};
    localparam logic [2:0]  V_Q    [NV] = '{3'd5, 3'd2, 3'd7, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0};

    function automatic logic [11:0] fold(input logic [47:0] d);
        return d[47:36] ^ d[35:24] ^ d[23:12] ^ d[11:0];
    endfunction

    task automatic check_res(input string req, input int kind,
                             input logic [7:0] mask, input logic [2:0] q);
        logic [7:0] exp_id;
        logic       ok;
        exp_id = (kind == 1) ? 8'd1 : 8'd0;
        ok = res_valid && (res_fwd == (kind == 0)) && (res_drop == (kind != 0))
             && res_mask == mask && res_queue == q && (kind == 0 || res_drop_id == exp_id);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got v=%0b fwd=%0b drop=%0b id=%0d mask=%h q=%0d, expected kind=%0d id=%0d mask=%h q=%0d",
                     req, res_valid, res_fwd, res_drop, res_drop_id, res_mask, res_queue,
                     kind, exp_id, mask, q);
        end
    endtask

    task automatic check_idle(input string req);
        tests++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: res_valid=%0b expected 0", req, res_valid);
        end
    endtask

    task automatic drive_hdr(input logic [47:0] da, input logic [2:0] src, input logic [47:0] sa);
        hdr_valid    = 1'b1;
        hdr_src_port = src;
        hdr_data     = {da, sa, 16'h0800 ^ sa[15:0]};
    endtask

    task automatic set_tbl(input logic [1:0] way, input logic v, input logic [47:0] a,
                           input logic [7:0] m, input logic [2:0] q);
        tbl_we = 1'b1; tbl_way = way; tbl_index = fold(a);
        tbl_valid = v; tbl_addr = a; tbl_mask = m; tbl_queue = q;
    endtask

    task automatic write_tbl(input logic [1:0] way, input logic v, input logic [47:0] a,
                             input logic [7:0] m, input logic [2:0] q);
        @(negedge clk);
        set_tbl(way, v, a, m, q);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic set_en(input logic [2:0] p, input logic on);
        @(negedge clk);
        en_we = 1'b1; en_port = p; en_on = on;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    // Single lookup; result sampled two negedges after the drive.
    task automatic lookup(input logic [47:0] da, input logic [2:0] src, input string req,
                          input int kind, input logic [7:0] m, input logic [2:0] q);
        @(negedge clk);
        drive_hdr(da, src, 48'h0A0B_0C0D_0E0F);
        @(negedge clk);
        hdr_valid = 1'b0;
        @(negedge clk);
        check_res(req, kind, m, q);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R1: watchdog expired, actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R9 reset output idle");

        // R9: ports disabled after reset
        lookup(A_DA, 3'd0, "R9 ports disabled after reset", 2, 8'h00, 3'd0);
        // R9: table empty after reset
        set_en(3'd0, 1'b1);
        lookup(A_DA, 3'd0, "R9 table empty after reset", 1, 8'h00, 3'd0);

        for (int p = 1; p < 7; p++) set_en(3'(p), 1'b1);
        write_tbl(2'd0, 1'b1, A_DA, 8'h03, 3'd5);
        write_tbl(2'd2, 1'b1, B_DA, 8'h80, 3'd2);   // same index as A, other way
        write_tbl(2'd3, 1'b1, C_DA, 8'h10, 3'd7);
        write_tbl(2'd1, 1'b1, E_DA, 8'h04, 3'd1);   // duplicate: way 1 wins
        write_tbl(2'd3, 1'b1, E_DA, 8'h08, 3'd6);
        write_tbl(2'd0, 1'b0, F_DA, 8'hFF, 3'd3);   // invalid entry

        // Vector table streamed back to back (R1..R7, R10 by varying source bytes)
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_res($sformatf("R1/R2/R3/R4/R5/R6/R7/R10 vector %0d", i - 2),
                                  V_KIND[i-2], V_MASK[i-2], V_Q[i-2]);
            if (i < NV) drive_hdr(V_DA[i], V_SRC[i], {40'h0, 8'(i * 37)});
            else        hdr_valid = 1'b0;
        end
        @(negedge clk);
        check_idle("R1 no extra result after stream");

        // R1 exact latency of a lone header
        @(negedge clk);
        drive_hdr(C_DA, 3'd2, 48'h1);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_idle("R1 no result after one cycle");
        @(negedge clk);
        check_res("R1 result after two cycles", 0, 8'h10, 3'd7);
        @(negedge clk);
        check_idle("R1 single result pulse");

        // R10: very different source and type bytes, same destination
        @(negedge clk);
        hdr_valid = 1'b1; hdr_src_port = 3'd3; hdr_data = {E_DA, 48'hFFFF_FFFF_FFFF, 16'hFFFF};
        @(negedge clk);
        hdr_valid = 1'b0;
        @(negedge clk);
        check_res("R10 source/type ignored", 0, 8'h04, 3'd1);

        // R8: write and lookup in the same cycle, then lookup again
        @(negedge clk);
        drive_hdr(G_DA, 3'd1, 48'h2);
        set_tbl(2'd1, 1'b1, G_DA, 8'h20, 3'd4);
        @(negedge clk);
        tbl_we = 1'b0;
        drive_hdr(G_DA, 3'd1, 48'h3);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_res("R8 same-cycle write not seen", 1, 8'h00, 3'd0);
        @(negedge clk);
        check_res("R8 later lookup sees write", 0, 8'h20, 3'd4);

        // R6: invalidating a live entry removes the hit
        write_tbl(2'd1, 1'b0, G_DA, 8'h20, 3'd4);
        lookup(G_DA, 3'd1, "R6 invalidated entry misses", 1, 8'h00, 3'd0);

        // R11: enable change in the same cycle as a header
        @(negedge clk);
        drive_hdr(A_DA, 3'd6, 48'h4);
        en_we = 1'b1; en_port = 3'd6; en_on = 1'b0;
        @(negedge clk);
        en_we = 1'b0;
        drive_hdr(A_DA, 3'd6, 48'h5);
        @(negedge clk);
        hdr_valid = 1'b0;
        check_res("R11 same-cycle disable not seen", 0, 8'h03, 3'd5);
        @(negedge clk);
        check_res("R11 later header sees disable", 2, 8'h00, 3'd0);

        // R5: re-enable port 7 and the same address now forwards
        set_en(3'd7, 1'b1);
        lookup(A_DA, 3'd7, "R5 re-enabled port forwards", 0, 8'h03, 3'd5);

        // R9: reset mid-run clears outputs, enables and table
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R9 idle after second reset");
        lookup(A_DA, 3'd1, "R9 enables cleared by reset", 2, 8'h00, 3'd0);
        set_en(3'd1, 1'b1);
        lookup(A_DA, 3'd1, "R9 table cleared by reset", 1, 8'h00, 3'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule